// File: doc/BRIEF.md
# Kinetic Synapse Bank with Scaled Weighted Accumulation

This block keeps one postsynaptic current value per source neuron and advances it with a two-state receptor rule. Each update is driven by one sample of a source's membrane potential. While that potential is above a supplied threshold, transmitter is present and the current moves toward 1 by a fixed fraction of the remaining gap. Otherwise the current falls toward 0 by a larger fixed fraction of itself. The two fractions are set by right-shift amounts. Their default ratio of four mirrors a closing rate about four times the opening rate. The current is unsigned fixed point with 11 fraction bits and is held inside [0, 1].

On request, the block computes the stimulus for one target neuron. It walks every source in ascending order and reads the weight for each (target, source) pair from an external memory. That memory has one-cycle read latency. The block multiplies each weight by that source's current and sums the products in a wide accumulator. It then scales the total by a coefficient captured at the request and saturates the result to the stimulus width. The coefficient carries 9 fraction bits, so 31 and 16 give about 0.0605 and 0.03125. The surrounding neuron pipeline drives the source samples and requests one target sweep after another.

Top module: `syn_kinetic_accum`

## Requirements
- R1: After reset every synaptic current is 0, `wmem_rd_en` and `stim_valid` are low, and a sweep over any weights returns a stimulus of 0.
- R2: A sample with `pre_valid` high and signed `pre_v` strictly greater than signed `pre_thr` sets that source's current to cur + ((2048 − cur) >> RISE_SH), limited to 2048. Here 2048 represents 1.0.
- R3: A sample with `pre_v` less than or equal to `pre_thr` sets the current to cur − (cur >> FALL_SH). Equality counts as no transmitter.
- R4: A current never exceeds 2048 and never goes below 0, however many samples arrive.
- R5: A sample changes only the current of the source given by `pre_idx`.
- R6: When `sweep_start` is sampled high while the block is idle, `wmem_rd_en` rises in the next cycle. It stays high for exactly N_SRC consecutive cycles, with `wmem_src` counting 0, 1, … N_SRC−1 and `wmem_tgt` holding the requested target. A `sweep_start` that arrives while a sweep is in progress is ignored.
- R7: `wmem_rdata` is taken one cycle after its address. The result is floor(Σj W(t,j)·Is(j)·coef / 2^20), where W has 11 fraction bits, Is has 11 and coef has 9, leaving 11 fraction bits in `stim`.
- R8: `stim_valid` is high for exactly one cycle, N_SRC+2 cycles after the edge that samples `sweep_start`, and `stim_tgt` then shows the swept target.
- R9: `stim` saturates to the largest positive or most negative STIM_W-bit signed value when the scaled sum exceeds that range.
- R10: Each sweep starts from an empty sum, so a repeated sweep with unchanged inputs returns the same value.
- R11: The coefficient used is the one present on `sweep_coef` at the edge that accepts the sweep. Later changes have no effect on that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_valid | input | 1 | Presynaptic sample strobe |
| pre_idx | input | IDX_W | Source neuron of the sample |
| pre_v | input | 16 | Signed membrane potential of the source |
| pre_thr | input | 16 | Signed transmitter threshold |
| sweep_start | input | 1 | Request a stimulus sweep |
| sweep_tgt | input | IDX_W | Target neuron of the sweep |
| sweep_coef | input | 10 | Unsigned scale coefficient, 9 fraction bits |
| wmem_rd_en | output | 1 | Weight memory read strobe |
| wmem_tgt | output | IDX_W | Weight row (target) |
| wmem_src | output | IDX_W | Weight column (source) |
| wmem_rdata | input | 12 | Signed weight, 11 fraction bits, one cycle after the read |
| stim_valid | output | 1 | Stimulus result strobe |
| stim_tgt | output | IDX_W | Target of the result |
| stim | output | STIM_W | Signed stimulus, 11 fraction bits |

## Verification
The bench builds the block with four sources and a 12-bit stimulus. With only four sources, each current can be probed on its own by loading a one-hot weight row. Every target row can also be swept under both coefficients, and the complete address sequence and result timing can be compared cycle by cycle. The narrow stimulus width lets full-scale positive and negative weights drive the scaled sum past both saturation limits.

// File: rtl/syn_kin_pkg.sv
package syn_kin_pkg;

    localparam int IS_W      = 12;
    localparam int IS_FRAC   = 11;
    localparam int W_W       = 12;
    localparam int W_FRAC    = 11;
    localparam int V_W       = 16;
    localparam int COEF_W    = 10;
    localparam int COEF_FRAC = 9;
    localparam int STIM_FRAC = 11;
    localparam int PROD_W    = W_W + IS_W + 1;
    localparam int SCALE_SH  = W_FRAC + IS_FRAC + COEF_FRAC - STIM_FRAC;

    localparam logic [IS_W-1:0] IS_ONE = IS_W'(1 << IS_FRAC);

    typedef logic [IS_W-1:0]          is_t;
    typedef logic signed [W_W-1:0]    wgt_t;
    typedef logic signed [V_W-1:0]    vmem_t;
    typedef logic [COEF_W-1:0]        coef_t;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_READ,
        SW_DRAIN,
        SW_SCALE
    } sweep_st_e;

    typedef struct packed {
        logic vld;
        logic first;
    } rd_tag_t;

    // One discrete step of the receptor kinetics.
    function automatic is_t is_step(input is_t cur, input logic tx,
                                    input int unsigned rise_sh,
                                    input int unsigned fall_sh);
        logic [IS_W:0] gap;
        logic [IS_W:0] nxt;
        if (tx) begin
            if (cur >= IS_ONE) begin
                nxt = {1'b0, IS_ONE};
            end else begin
                gap = {1'b0, IS_ONE} - {1'b0, cur};
                nxt = {1'b0, cur} + (gap >> rise_sh);
                if (nxt > {1'b0, IS_ONE}) nxt = {1'b0, IS_ONE};
            end
        end else begin
            nxt = {1'b0, cur} - ({1'b0, cur} >> fall_sh);
        end
        return nxt[IS_W-1:0];
    endfunction

endpackage

// File: rtl/syn_kin_bank.sv
module syn_kin_bank
    import syn_kin_pkg::*;
#(
    parameter int N_SRC   = 256,
    parameter int IDX_W   = 8,
    parameter int RISE_SH = 6,
    parameter int FALL_SH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_valid,
    input  logic [IDX_W-1:0] pre_idx,
    input  vmem_t            pre_v,
    input  vmem_t            pre_thr,
    input  logic [IDX_W-1:0] rd_idx,
    output is_t              rd_is,
    output logic             upd_we,
    output is_t              upd_val
);

    is_t  is_q [N_SRC];
    logic tx;
    is_t  cur;

    always_comb begin
        tx      = (pre_v > pre_thr);
        upd_we  = pre_valid && (32'(pre_idx) < N_SRC);
        cur     = upd_we ? is_q[pre_idx] : '0;
        upd_val = is_step(cur, tx, RISE_SH, FALL_SH);
        rd_is   = (32'(rd_idx) < N_SRC) ? is_q[rd_idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SRC; i++) is_q[i] <= '0;
        end else if (upd_we) begin
            is_q[pre_idx] <= upd_val;
        end
    end

endmodule

// File: rtl/syn_sweep_ctrl.sv
module syn_sweep_ctrl
    import syn_kin_pkg::*;
#(
    parameter int N_SRC = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] tgt_in,
    input  coef_t            coef_in,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_src,
    output logic [IDX_W-1:0] rd_tgt,
    output coef_t            coef_q,
    output rd_tag_t          tag_d,
    output logic [IDX_W-1:0] src_d,
    output logic             fin
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SRC - 1);

    sweep_st_e        st;
    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] tgt_q;
    logic [IDX_W-1:0] src_q;
    coef_t            coef_r;
    rd_tag_t          tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SW_IDLE;
            cnt    <= '0;
            tgt_q  <= '0;
            src_q  <= '0;
            coef_r <= '0;
            tag_q  <= '0;
        end else begin
            tag_q <= '0;
            case (st)
                SW_IDLE: begin
                    if (start) begin
                        st     <= SW_READ;
                        cnt    <= '0;
                        tgt_q  <= tgt_in;
                        coef_r <= coef_in;
                    end
                end
                SW_READ: begin
                    tag_q.vld   <= 1'b1;
                    tag_q.first <= (cnt == '0);
                    src_q       <= cnt;
                    if (cnt == LAST) st <= SW_DRAIN;
                    else             cnt <= cnt + 1'b1;
                end
                SW_DRAIN: st <= SW_SCALE;
                SW_SCALE: st <= SW_IDLE;
                default:  st <= SW_IDLE;
            endcase
        end
    end

    assign rd_en  = (st == SW_READ);
    assign rd_src = cnt;
    assign rd_tgt = tgt_q;
    assign coef_q = coef_r;
    assign tag_d  = tag_q;
    assign src_d  = src_q;
    assign fin    = (st == SW_SCALE);

endmodule

// File: rtl/syn_mac_acc.sv
module syn_mac_acc
    import syn_kin_pkg::*;
#(
    parameter int N_SRC  = 256,
    parameter int STIM_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  rd_tag_t                  tag,
    input  wgt_t                     wdata,
    input  is_t                      is_val,
    input  coef_t                    coef,
    input  logic                     fin,
    output logic signed [STIM_W-1:0] stim,
    output logic                     stim_valid
);

    localparam int ACC_W = PROD_W + $clog2(N_SRC) + 1;
    localparam int SC_W  = ACC_W + COEF_W + 1;
    localparam logic signed [SC_W-1:0] SAT_HI = SC_W'((64'sd1 <<< (STIM_W - 1)) - 64'sd1);
    localparam logic signed [SC_W-1:0] SAT_LO = -SAT_HI - SC_W'(1);

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_x;
    logic signed [ACC_W-1:0]  acc;
    logic signed [SC_W-1:0]   scaled;
    logic signed [SC_W-1:0]   shifted;
    logic signed [STIM_W-1:0] sat;

    always_comb begin
        prod    = $signed({{(PROD_W - W_W){wdata[W_W-1]}}, wdata})
                * $signed({{(PROD_W - IS_W){1'b0}}, is_val});
        prod_x  = ACC_W'(prod);
        scaled  = $signed({{(SC_W - ACC_W){acc[ACC_W-1]}}, acc})
                * $signed({{(SC_W - COEF_W){1'b0}}, coef});
        shifted = scaled >>> SCALE_SH;
        if (shifted > SAT_HI)      sat = SAT_HI[STIM_W-1:0];
        else if (shifted < SAT_LO) sat = SAT_LO[STIM_W-1:0];
        else                       sat = shifted[STIM_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            stim       <= '0;
            stim_valid <= 1'b0;
        end else begin
            stim_valid <= fin;
            if (tag.vld) acc <= tag.first ? prod_x : acc + prod_x;
            if (fin)     stim <= sat;
        end
    end

endmodule

// File: rtl/syn_kinetic_accum.sv
module syn_kinetic_accum
    import syn_kin_pkg::*;
#(
    parameter int   N_SRC   = 256,
    parameter int   RISE_SH = 6,
    parameter int   FALL_SH = 4,
    parameter int   STIM_W  = 16,
    localparam int  IDX_W   = $clog2(N_SRC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pre_valid,
    input  logic [IDX_W-1:0]         pre_idx,
    input  logic signed [V_W-1:0]    pre_v,
    input  logic signed [V_W-1:0]    pre_thr,
    input  logic                     sweep_start,
    input  logic [IDX_W-1:0]         sweep_tgt,
    input  logic [COEF_W-1:0]        sweep_coef,
    output logic                     wmem_rd_en,
    output logic [IDX_W-1:0]         wmem_tgt,
    output logic [IDX_W-1:0]         wmem_src,
    input  logic signed [W_W-1:0]    wmem_rdata,
    output logic                     stim_valid,
    output logic [IDX_W-1:0]         stim_tgt,
    output logic signed [STIM_W-1:0] stim
);

    is_t              rd_is;
    logic             upd_we;
    is_t              upd_val;
    coef_t            coef_q;
    rd_tag_t          tag_d;
    logic [IDX_W-1:0] src_d;
    logic             fin;

    syn_kin_bank #(
        .N_SRC  (N_SRC),
        .IDX_W  (IDX_W),
        .RISE_SH(RISE_SH),
        .FALL_SH(FALL_SH)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .pre_valid(pre_valid),
        .pre_idx  (pre_idx),
        .pre_v    (pre_v),
        .pre_thr  (pre_thr),
        .rd_idx   (src_d),
        .rd_is    (rd_is),
        .upd_we   (upd_we),
        .upd_val  (upd_val)
    );

    syn_sweep_ctrl #(
        .N_SRC(N_SRC),
        .IDX_W(IDX_W)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (sweep_start),
        .tgt_in (sweep_tgt),
        .coef_in(sweep_coef),
        .rd_en  (wmem_rd_en),
        .rd_src (wmem_src),
        .rd_tgt (wmem_tgt),
        .coef_q (coef_q),
        .tag_d  (tag_d),
        .src_d  (src_d),
        .fin    (fin)
    );

    syn_mac_acc #(
        .N_SRC (N_SRC),
        .STIM_W(STIM_W)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .tag       (tag_d),
        .wdata     (wmem_rdata),
        .is_val    (rd_is),
        .coef      (coef_q),
        .fin       (fin),
        .stim      (stim),
        .stim_valid(stim_valid)
    );

    assign stim_tgt = wmem_tgt;

endmodule

// File: rtl/syn_kinetic_accum_chk.sv
module syn_kinetic_accum_chk
    import syn_kin_pkg::*;
#(
    parameter int  N_SRC = 256,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst,
    input logic             wmem_rd_en,
    input logic [IDX_W-1:0] wmem_src,
    input logic [IDX_W-1:0] wmem_tgt,
    input logic             stim_valid,
    input logic             upd_we,
    input is_t              upd_val
);

    p_is_bound_r4: assert property (@(posedge clk) disable iff (rst)
        upd_we |-> (upd_val <= IS_ONE));

    p_first_src_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(wmem_rd_en) |-> (wmem_src == '0));

    p_src_step_r6: assert property (@(posedge clk) disable iff (rst)
        (wmem_rd_en && $past(wmem_rd_en)) |-> (wmem_src == IDX_W'($past(wmem_src) + 1'b1)));

    p_tgt_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (wmem_rd_en && $past(wmem_rd_en)) |-> $stable(wmem_tgt));

    p_src_range_r6: assert property (@(posedge clk) disable iff (rst)
        wmem_rd_en |-> (32'(wmem_src) < N_SRC));

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        stim_valid |=> !stim_valid);

    p_valid_after_read_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(wmem_rd_en) |-> ##2 stim_valid);

    p_no_read_at_valid_r8: assert property (@(posedge clk) disable iff (rst)
        stim_valid |-> !wmem_rd_en);

endmodule

bind syn_kinetic_accum syn_kinetic_accum_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wmem_rd_en(wmem_rd_en),
    .wmem_src  (wmem_src),
    .wmem_tgt  (wmem_tgt),
    .stim_valid(stim_valid),
    .upd_we    (upd_we),
    .upd_val   (upd_val)
);

// File: tb/sim_syn_kinetic_accum.sv
module sim_syn_kinetic_accum;

    localparam int N  = 4;
    localparam int IW = 2;
    localparam int SW = 12;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 pre_valid = 1'b0;
    logic [IW-1:0]        pre_idx = '0;
    logic signed [15:0]   pre_v = '0;
    logic signed [15:0]   pre_thr = '0;
    logic                 sweep_start = 1'b0;
    logic [IW-1:0]        sweep_tgt = '0;
    logic [9:0]           sweep_coef = '0;
    logic                 wmem_rd_en;
    logic [IW-1:0]        wmem_tgt;
    logic [IW-1:0]        wmem_src;
    logic signed [11:0]   wmem_rdata = '0;
    logic                 stim_valid;
    logic [IW-1:0]        stim_tgt;
    logic signed [SW-1:0] stim;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    int  is_m [N];
    logic signed [11:0] wm [N*N];

    syn_kinetic_accum #(.N_SRC(N), .STIM_W(SW)) u0 (
        .clk(clk), .rst(rst),
        .pre_valid(pre_valid), .pre_idx(pre_idx), .pre_v(pre_v), .pre_thr(pre_thr),
        .sweep_start(sweep_start), .sweep_tgt(sweep_tgt), .sweep_coef(sweep_coef),
        .wmem_rd_en(wmem_rd_en), .wmem_tgt(wmem_tgt), .wmem_src(wmem_src),
        .wmem_rdata(wmem_rdata),
        .stim_valid(stim_valid), .stim_tgt(stim_tgt), .stim(stim)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (wmem_rd_en) wmem_rdata <= wm[{wmem_tgt, wmem_src}];
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_step(input int cur, input bit tx);
        int n;
        if (tx) begin
            n = cur + ((2048 - cur) >> 6);
            if (n > 2048) n = 2048;
        end else begin
            n = cur - (cur >> 4);
        end
        return n;
    endfunction

    function automatic longint exp_stim(input int t, input int coef);
        longint acc = 0;
        for (int j = 0; j < N; j++) acc += longint'(wm[t*N+j]) * longint'(is_m[j]);
        acc = (acc * coef) >>> 20;
        if (acc > 2047)  acc = 2047;
        if (acc < -2048) acc = -2048;
        return acc;
    endfunction

    task automatic pre(input int idx, input int v, input int thr);
        @(negedge clk);
        pre_valid = 1'b1;
        pre_idx   = IW'(idx);
        pre_v     = 16'(v);
        pre_thr   = 16'(thr);
        @(negedge clk);
        pre_valid = 1'b0;
        is_m[idx] = m_step(is_m[idx], v > thr);
    endtask

    task automatic sweep(input int t, input int coef, input bit restart, output longint got);
        bit seq_ok = 1'b1;
        bit vld_ok = 1'b1;
        bit tgt_ok = 1'b1;
        got = 0;
        @(negedge clk);
        sweep_start = 1'b1;
        sweep_tgt   = IW'(t);
        sweep_coef  = 10'(coef);
        for (int k = 0; k <= N + 3; k++) begin
            @(negedge clk);
            if (k == 0) sweep_start = 1'b0;
            if (restart && k == 1) begin
                sweep_start = 1'b1;
                sweep_tgt   = IW'(t ^ 1);
                sweep_coef  = 10'(1023 - coef);
            end
            if (restart && k == 2) sweep_start = 1'b0;
            if (wmem_rd_en !== (k < N)) seq_ok = 1'b0;
            if (k < N && (wmem_src !== IW'(k) || wmem_tgt !== IW'(t))) seq_ok = 1'b0;
            if (stim_valid !== (k == N + 2)) vld_ok = 1'b0;
            if (k == N + 2) begin
                got = longint'(stim);
                if (stim_tgt !== IW'(t)) tgt_ok = 1'b0;
            end
        end
        chk(seq_ok, "R6 read sequence", seq_ok, 1);
        chk(vld_ok && tgt_ok, "R8 result timing", vld_ok && tgt_ok, 1);
    endtask

    task automatic sweep_chk(input int t, input int coef, input bit restart, input string req);
        longint got;
        longint exp;
        exp = exp_stim(t, coef);
        sweep(t, coef, restart, got);
        chk(got == exp, req, got, exp);
    endtask

    task automatic load_pattern(input int seed);
        for (int i = 0; i < N*N; i++) wm[i] = 12'(((i * 733 + seed * 97 + 129) % 4096) - 2048);
    endtask

    task automatic probe(input int j, input string req);
        for (int i = 0; i < N; i++) wm[3*N+i] = (i == j) ? 12'sd2047 : 12'sd0;
        sweep_chk(3, 1023, 1'b0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        longint g1;
        longint g2;
        for (int j = 0; j < N; j++) is_m[j] = 0;
        load_pattern(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        chk(!wmem_rd_en && !stim_valid && stim == 0, "R1 reset outputs",
            {wmem_rd_en, stim_valid}, 0);
        sweep_chk(0, 31, 1'b0, "R1 zero currents give zero stimulus");

        // R2 rises on source 1, R3 decay and equality on source 2, R3 decay at zero on 0
        repeat (5) pre(1, 100, 0);
        repeat (8) pre(2, 500, -300);
        repeat (3) pre(2, -5, -5);
        pre(0, -200, -100);
        probe(0, "R3 decay from zero");
        probe(1, "R2 rise steps");
        probe(2, "R3 decay and equal threshold");
        probe(3, "R5 untouched source stays zero");

        // R4 drive every source towards the top
        for (int s = 0; s < N; s++) repeat (40) pre(s, 1000, 10);
        for (int j = 0; j < N; j++) begin
            chk(is_m[j] <= 2048, "R4 model bound", is_m[j], 2048);
            probe(j, "R4 current held at or below one");
        end

        // R9 saturation both ways
        for (int i = 0; i < N; i++) begin
            wm[0*N+i] = 12'sd2047;
            wm[1*N+i] = -12'sd2048;
        end
        sweep_chk(0, 1023, 1'b0, "R9 positive saturation");
        chk(stim == 2047, "R9 positive limit", stim, 2047);
        sweep_chk(1, 1023, 1'b0, "R9 negative saturation");
        chk(stim == -2048, "R9 negative limit", stim, -2048);

        // mixed currents, then all targets under both coefficients
        repeat (6) pre(1, -50, 0);
        repeat (12) pre(3, 0, 1);
        load_pattern(1);
        for (int t = 0; t < N; t++) sweep_chk(t, 31, 1'b0, "R7 weighted sum coefficient 31");
        load_pattern(2);
        for (int t = 0; t < N; t++) sweep_chk(t, 16, 1'b0, "R7 weighted sum coefficient 16");

        // R10 repeat sweep gives same result
        sweep(2, 31, 1'b0, g1);
        sweep(2, 31, 1'b0, g2);
        chk(g1 == g2 && g1 == exp_stim(2, 31), "R10 accumulator cleared per sweep", g2, g1);

        // R6 start while busy ignored, R11 coefficient captured at start
        sweep_chk(1, 31, 1'b1, "R11 coefficient held despite restart");
        sweep_chk(2, 16, 1'b1, "R6 start during sweep ignored");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule